// File: doc/BRIEF.md
# Configurable GPIO Port Bank

This block is a set of general-purpose I/O ports that a small CPU reaches over an 8-bit register bus. Every pin has its own data bit and configuration bit. Together these two bits choose one of four pin states. The block turns the pair into three pad controls: an output enable, an output value and a weak pull-up enable. Each bidirectional port also has a read-only address that returns the pin levels after they pass through a synchronizer.

The bank holds four ports:

- Port A is a full 8-pin bidirectional port.
- Port B has eight pins. The top two are input-only, and a bus write that sets bit 7 of its data register sends a one-cycle halt request to the rest of the chip.
- Port C is a 4-pin bidirectional port. Its unused upper bits read as zero.
- Port D is an 8-bit output-only latch. It goes to all ones while reset is held.

The bus has a single cycle. Writes take effect at the clock edge, and reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: For every bidirectional pin the pad controls follow from the pair {config, data}: output enable = config, output value = data, and pull-up enable = data AND NOT config. The four codes are 00 (high-impedance input), 01 (input with weak pull-up), 10 (driven low) and 11 (driven high).
- R2: With default parameters, port A uses addresses 0x0 (data), 0x1 (config) and 0x2 (pins). Port B uses 0x4, 0x5 and 0x6. Port C uses 0x8, 0x9 and 0xA. Port D uses 0xC. A write to a data or config address updates that register at the next clock edge, and a read returns the register's current value at once.
- R3: A pin-read address returns each pin input delayed by exactly two clock edges, with no other processing.
- R4: On port B, config bits 7 and 6 stay zero whatever is written, and they read back as zero. As a result, b_oe[7:6] is never set.
- R5: A write to the port B data address with write-data bit 7 set makes halt_req high for exactly the following clock cycle. No other bus access makes halt_req high, and it stays low while reset is asserted.
- R6: Port C has 4 pins. Bits 7..4 of its data, config and pin reads are zero, and writes to those bits are discarded.
- R7: Port D has no config or pin address. Its value is written at 0xC, can be read back there, and drives d_out. While rst_n is low, d_out is 0xFF.
- R8: While rst_n is low, all data and config registers of ports A, B and C are zero. Every one of their pins is therefore a high-impedance input (all enables and pull-ups are 0), and bus writes are ignored.
- R9: Reads of any unmapped address return 0x00. Writes to unmapped addresses and to pin-read addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| a_pin_in | input | 8 | Port A pin levels |
| a_oe | output | 8 | Port A output enables |
| a_out | output | 8 | Port A output values |
| a_pu | output | 8 | Port A pull-up enables |
| b_pin_in | input | 8 | Port B pin levels |
| b_oe | output | 8 | Port B output enables |
| b_out | output | 8 | Port B output values |
| b_pu | output | 8 | Port B pull-up enables |
| c_pin_in | input | 4 | Port C pin levels |
| c_oe | output | 4 | Port C output enables |
| c_out | output | 4 | Port C output values |
| c_pu | output | 4 | Port C pull-up enables |
| d_out | output | 8 | Port D output latch |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, the default address map, 4 pins on port C, and two input-only pins on port B with bit 7 as the halt bit. This configuration makes the exact two-edge pin latency, the masked config bits and the halt pulse visible cycle by cycle, and the bench's reference model checks them. Random bus traffic aimed mostly at mapped addresses covers the following cases:

- back-to-back halt writes;
- writes to pin and unmapped addresses;
- every pin code on all ports.

A second reset in the middle of the run exercises R7 and R8 again.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int C_PINS      = 4,
  parameter int B_IN_ONLY   = 2,
  parameter int HALT_BIT    = 7,
  parameter logic [ADDR_W-1:0] A_DATA = 4'h0,
  parameter logic [ADDR_W-1:0] A_CFG  = 4'h1,
  parameter logic [ADDR_W-1:0] A_PIN  = 4'h2,
  parameter logic [ADDR_W-1:0] B_DATA = 4'h4,
  parameter logic [ADDR_W-1:0] B_CFG  = 4'h5,
  parameter logic [ADDR_W-1:0] B_PIN  = 4'h6,
  parameter logic [ADDR_W-1:0] C_DATA = 4'h8,
  parameter logic [ADDR_W-1:0] C_CFG  = 4'h9,
  parameter logic [ADDR_W-1:0] C_PIN  = 4'hA,
  parameter logic [ADDR_W-1:0] D_DATA = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        a_pin_in,
  output logic [7:0]        a_oe,
  output logic [7:0]        a_out,
  output logic [7:0]        a_pu,
  input  logic [7:0]        b_pin_in,
  output logic [7:0]        b_oe,
  output logic [7:0]        b_out,
  output logic [7:0]        b_pu,
  input  logic [C_PINS-1:0] c_pin_in,
  output logic [C_PINS-1:0] c_oe,
  output logic [C_PINS-1:0] c_out,
  output logic [C_PINS-1:0] c_pu,
  output logic [7:0]        d_out,
  output logic              halt_req
);
  localparam int W     = 8;
  localparam int B_IO  = W - B_IN_ONLY;
  localparam logic [W-1:0] B_CFG_MASK = {{B_IN_ONLY{1'b0}}, {B_IO{1'b1}}};
  localparam int C_PAD = W - C_PINS;

  logic [W-1:0]      a_data, a_cfg, b_data, b_cfg, d_data;
  logic [C_PINS-1:0] c_data, c_cfg;
  logic              halt_q;
  logic [W-1:0]      a_sync [SYNC_STAGES];
  logic [W-1:0]      b_sync [SYNC_STAGES];
  logic [C_PINS-1:0] c_sync [SYNC_STAGES];

  wire wr_a_d = bus_we && (bus_addr == A_DATA);
  wire wr_a_c = bus_we && (bus_addr == A_CFG);
  wire wr_b_d = bus_we && (bus_addr == B_DATA);
  wire wr_b_c = bus_we && (bus_addr == B_CFG);
  wire wr_c_d = bus_we && (bus_addr == C_DATA);
  wire wr_c_c = bus_we && (bus_addr == C_CFG);
  wire wr_d_d = bus_we && (bus_addr == D_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_data <= '0;
      a_cfg  <= '0;
      b_data <= '0;
      b_cfg  <= '0;
      c_data <= '0;
      c_cfg  <= '0;
      d_data <= '1;
      halt_q <= 1'b0;
    end else begin
      if (wr_a_d) a_data <= bus_wdata;
      if (wr_a_c) a_cfg  <= bus_wdata;
      if (wr_b_d) b_data <= bus_wdata;
      if (wr_b_c) b_cfg  <= bus_wdata & B_CFG_MASK;
      if (wr_c_d) c_data <= bus_wdata[C_PINS-1:0];
      if (wr_c_c) c_cfg  <= bus_wdata[C_PINS-1:0];
      if (wr_d_d) d_data <= bus_wdata;
      halt_q <= wr_b_d && bus_wdata[HALT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        a_sync[i] <= '0;
        b_sync[i] <= '0;
        c_sync[i] <= '0;
      end
    end else begin
      a_sync[0] <= a_pin_in;
      b_sync[0] <= b_pin_in;
      c_sync[0] <= c_pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        a_sync[i] <= a_sync[i-1];
        b_sync[i] <= b_sync[i-1];
        c_sync[i] <= c_sync[i-1];
      end
    end
  end

  assign a_oe  = a_cfg;
  assign a_out = a_data;
  assign a_pu  = a_data & ~a_cfg;
  assign b_oe  = b_cfg;
  assign b_out = b_data;
  assign b_pu  = b_data & ~b_cfg;
  assign c_oe  = c_cfg;
  assign c_out = c_data;
  assign c_pu  = c_data & ~c_cfg;
  assign d_out = d_data;
  assign halt_req = halt_q;

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == A_DATA) bus_rdata = a_data;
    else if (bus_addr == A_CFG)  bus_rdata = a_cfg;
    else if (bus_addr == A_PIN)  bus_rdata = a_sync[SYNC_STAGES-1];
    else if (bus_addr == B_DATA) bus_rdata = b_data;
    else if (bus_addr == B_CFG)  bus_rdata = b_cfg;
    else if (bus_addr == B_PIN)  bus_rdata = b_sync[SYNC_STAGES-1];
    else if (bus_addr == C_DATA) bus_rdata = {{C_PAD{1'b0}}, c_data};
    else if (bus_addr == C_CFG)  bus_rdata = {{C_PAD{1'b0}}, c_cfg};
    else if (bus_addr == C_PIN)  bus_rdata = {{C_PAD{1'b0}}, c_sync[SYNC_STAGES-1]};
    else if (bus_addr == D_DATA) bus_rdata = d_data;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int ADDR_W    = 4,
  parameter int C_PINS    = 4,
  parameter int B_IN_ONLY = 2,
  parameter int HALT_BIT  = 7,
  parameter logic [ADDR_W-1:0] A_CFG  = 4'h1,
  parameter logic [ADDR_W-1:0] B_DATA = 4'h4,
  parameter logic [ADDR_W-1:0] B_CFG  = 4'h5,
  parameter logic [ADDR_W-1:0] C_DATA = 4'h8,
  parameter logic [ADDR_W-1:0] C_CFG  = 4'h9,
  parameter logic [ADDR_W-1:0] C_PIN  = 4'hA,
  parameter logic [ADDR_W-1:0] D_DATA = 4'hC
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        a_oe,
  input logic [7:0]        d_out,
  input logic              halt_req
);
  localparam int C_PAD = 8 - C_PINS;

  p_oe_follows_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CFG) |=> (a_oe == $past(bus_wdata)));

  p_in_only_cfg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == B_CFG) |-> (bus_rdata[7 -: B_IN_ONLY] == '0));

  p_halt_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(bus_we && bus_addr == B_DATA && bus_wdata[HALT_BIT]));

  p_halt_follows_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == B_DATA && bus_wdata[HALT_BIT]) |=> halt_req);

  p_c_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == C_DATA || bus_addr == C_CFG || bus_addr == C_PIN)
      |-> (bus_rdata[7 -: C_PAD] == '0));

  p_d_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == D_DATA) |=> (d_out == $past(bus_wdata)));
endmodule

bind gpio_bank gpio_bank_chk #(
  .ADDR_W(ADDR_W), .C_PINS(C_PINS), .B_IN_ONLY(B_IN_ONLY), .HALT_BIT(HALT_BIT),
  .A_CFG(A_CFG), .B_DATA(B_DATA), .B_CFG(B_CFG), .C_DATA(C_DATA),
  .C_CFG(C_CFG), .C_PIN(C_PIN), .D_DATA(D_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .a_oe(a_oe),
  .d_out(d_out), .halt_req(halt_req)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] a_pin_in = '0, b_pin_in = '0;
  logic [3:0] c_pin_in = '0;
  logic [7:0] bus_rdata, a_oe, a_out, a_pu, b_oe, b_out, b_pu, d_out;
  logic [3:0] c_oe, c_out, c_pu;
  logic       halt_req;
  bit         done = 1'b0;

  int errors = 0;
  int checks = 0;

  gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .a_pin_in(a_pin_in), .a_oe(a_oe), .a_out(a_out), .a_pu(a_pu),
    .b_pin_in(b_pin_in), .b_oe(b_oe), .b_out(b_out), .b_pu(b_pu),
    .c_pin_in(c_pin_in), .c_oe(c_oe), .c_out(c_out), .c_pu(c_pu),
    .d_out(d_out), .halt_req(halt_req)
  );

  logic [7:0] m_ad, m_ac, m_bd, m_bc, m_d;
  logic [3:0] m_cd, m_cc;
  logic       m_halt;
  logic [7:0] ha [SYNC];
  logic [7:0] hb [SYNC];
  logic [3:0] hc [SYNC];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ad <= 0; m_ac <= 0; m_bd <= 0; m_bc <= 0; m_cd <= 0; m_cc <= 0;
      m_d <= 8'hFF; m_halt <= 0;
      for (int i = 0; i < SYNC; i++) begin ha[i] <= 0; hb[i] <= 0; hc[i] <= 0; end
    end else begin
      m_halt <= bus_we && bus_addr == 4'h4 && bus_wdata[7];
      ha[0] <= a_pin_in; hb[0] <= b_pin_in; hc[0] <= c_pin_in;
      for (int i = 1; i < SYNC; i++) begin ha[i] <= ha[i-1]; hb[i] <= hb[i-1]; hc[i] <= hc[i-1]; end
      if (bus_we)
        case (bus_addr)
          4'h0: m_ad <= bus_wdata;
          4'h1: m_ac <= bus_wdata;
          4'h4: m_bd <= bus_wdata;
          4'h5: m_bc <= bus_wdata & 8'h3F;
          4'h8: m_cd <= bus_wdata[3:0];
          4'h9: m_cc <= bus_wdata[3:0];
          4'hC: m_d  <= bus_wdata;
          default: ;
        endcase
    end
  end

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_ad;
      4'h1: return m_ac;
      4'h2: return ha[SYNC-1];
      4'h4: return m_bd;
      4'h5: return m_bc;
      4'h6: return hb[SYNC-1];
      4'h8: return {4'h0, m_cd};
      4'h9: return {4'h0, m_cc};
      4'hA: return {4'h0, hc[SYNC-1]};
      4'hC: return m_d;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    case (a)
      4'h2, 4'h6: return "R3";
      4'h5: return "R4";
      4'h8, 4'h9, 4'hA: return "R6";
      4'hC: return "R7";
      4'h0, 4'h1, 4'h4: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string t1, t4, t6;
      t1 = rst_n ? "R1" : "R8";
      t4 = rst_n ? "R4" : "R8";
      t6 = rst_n ? "R6" : "R8";
      chk(a_oe == m_ac, t1, "a_oe", a_oe, m_ac);
      chk(a_out == m_ad, t1, "a_out", a_out, m_ad);
      chk(a_pu == (m_ad & ~m_ac), t1, "a_pu", a_pu, m_ad & ~m_ac);
      chk(b_oe == m_bc, t4, "b_oe", b_oe, m_bc);
      chk(b_out == m_bd, t1, "b_out", b_out, m_bd);
      chk(b_pu == (m_bd & ~m_bc), t1, "b_pu", b_pu, m_bd & ~m_bc);
      chk(c_oe == m_cc, t6, "c_oe", {4'h0, c_oe}, {4'h0, m_cc});
      chk(c_out == m_cd, t6, "c_out", {4'h0, c_out}, {4'h0, m_cd});
      chk(c_pu == (m_cd & ~m_cc), t6, "c_pu", {4'h0, c_pu}, {4'h0, m_cd & ~m_cc});
      chk(d_out == m_d, "R7", "d_out", d_out, m_d);
      chk(halt_req == m_halt, "R5", "halt_req", {7'h0, halt_req}, {7'h0, m_halt});
    end
  end

  task automatic bus(input logic [3:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
    #1;
    chk(bus_rdata == exp_read(a), read_tag(a), "bus_rdata", bus_rdata, exp_read(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8/R5: write attempt during reset is ignored, halt stays low
    bus(4'h4, 1'b1, 8'hFF);
    bus(4'h1, 1'b1, 8'hFF);
    bus(4'hC, 1'b1, 8'h00);
    @(negedge clk); #2 rst_n = 1'b1;
    // R1: all four pin codes on port A (pins 0..3 = 00,01,10,11)
    bus(4'h0, 1'b1, 8'b1010_1010);
    bus(4'h1, 1'b1, 8'b1100_1100);
    bus(4'h0, 1'b0, 8'h00);
    bus(4'h1, 1'b0, 8'h00);
    // R4: input-only config bits masked
    bus(4'h5, 1'b1, 8'hFF);
    bus(4'h5, 1'b0, 8'h00);
    // R5: halt pulse, back-to-back, and bit7 clear gives none
    bus(4'h4, 1'b1, 8'h80);
    bus(4'h4, 1'b1, 8'h7F);
    bus(4'h4, 1'b1, 8'hC0);
    bus(4'h4, 1'b1, 8'h81);
    bus(4'h4, 1'b0, 8'h00);
    bus(4'h6, 1'b1, 8'h80);
    // R6: port C upper bits
    bus(4'h8, 1'b1, 8'hFF);
    bus(4'h9, 1'b1, 8'hA5);
    bus(4'h8, 1'b0, 8'h00);
    bus(4'h9, 1'b0, 8'h00);
    // R7: port D
    bus(4'hC, 1'b1, 8'h5A);
    bus(4'hC, 1'b0, 8'h00);
    // R3: pin latency
    a_pin_in = 8'h3C; b_pin_in = 8'hC3; c_pin_in = 4'h9;
    for (int i = 0; i < 4; i++) bus(4'h2, 1'b0, 8'h00);
    bus(4'h6, 1'b0, 8'h00);
    bus(4'hA, 1'b0, 8'h00);
    // R9: unmapped and pin-address writes
    bus(4'h2, 1'b1, 8'hFF);
    bus(4'hA, 1'b1, 8'hFF);
    for (int a = 0; a < 16; a++) bus(4'(a), 1'b1, 8'hEE);
    for (int a = 0; a < 16; a++) bus(4'(a), 1'b0, 8'h00);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a;
      a = ($urandom_range(0, 3) == 0) ? 4'($urandom) :
          4'($urandom_range(0, 3) * 4 + $urandom_range(0, 2));
      a_pin_in = 8'($urandom); b_pin_in = 8'($urandom); c_pin_in = 4'($urandom);
      bus(a, 1'($urandom_range(0, 1)), 8'($urandom));
      if (n == 1500) begin
        @(negedge clk); #2 rst_n = 1'b0;
        bus(4'h4, 1'b1, 8'h80);
        bus(4'h0, 1'b1, 8'hFF);
        @(negedge clk); #2 rst_n = 1'b1;
      end
    end
    bus(4'h0, 1'b0, 8'h00);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule